// File: doc/BRIEF.md
# Three-Leg Shoot-Through Envelope PWM Gate Generator

This block drives the six bridge switches of an impedance-source inverter from three modulating references that already carry their zero-sequence component. It compares each reference with a triangular carrier to set the normal upper/lower gate of every leg. It also builds two envelope signals that insert shoot-through on all three legs at once. The upper envelope follows the largest reference and is lifted by an offset K wherever that maximum sits at or below zero. The lower envelope follows the smallest reference and is pushed down by K wherever that minimum sits at or above zero. When the upper envelope falls below the carrier, every upper switch is forced on. When the lower envelope rises above the carrier, every lower switch is forced on. The boost is set by K alone, so the modulation index can stay at its ceiling. A smaller K gives more shoot-through.

References and carrier are signed two's-complement words of `DW` bits, with full scale taken as 2^(DW-1). The offset is an unsigned word of `DW-1` bits. The maximum, minimum and envelope arithmetic are registered once. The comparisons are then registered into the gate outputs, so every gate reflects the inputs presented two clock edges earlier.

Top module: `stpwm_gate_gen`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are 0.
- R2: Bit 0, 1 and 2 of `gate_hi` belong to legs a, b and c. Each is 1 when its leg's reference is strictly greater than the carrier.
- R3: Bit 0, 1 and 2 of `gate_lo` belong to legs a, b and c. Each is 1 when its leg's reference is strictly less than the carrier.
- R4: A leg whose reference equals the carrier has both gates at 0 unless a shoot-through force applies.
- R5: When the upper envelope is strictly below the carrier, all three bits of `gate_hi` are 1.
- R6: When the lower envelope is strictly above the carrier, all three bits of `gate_lo` are 1.
- R7: The upper envelope equals the maximum reference plus the clamped K when that maximum is at or below zero. Otherwise it equals the maximum. A maximum of exactly 0 is lifted.
- R8: The lower envelope equals the minimum reference minus the clamped K when that minimum is at or above zero. Otherwise it equals the minimum. A minimum of exactly 0 is lowered.
- R9: K is clamped to 2^(DW-2), which is half of full scale. Any larger value acts as exactly 2^(DW-2), and smaller values pass unchanged.
- R10: Gate outputs reflect the references, carrier and K sampled two rising clock edges earlier.
- R11: When neither envelope force applies, no leg has both gates at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_a | input | DW | Signed modulating reference, leg a |
| ref_b | input | DW | Signed modulating reference, leg b |
| ref_c | input | DW | Signed modulating reference, leg c |
| carrier | input | DW | Signed triangular carrier sample |
| k_off | input | DW-1 | Unsigned envelope offset K |
| gate_hi | output | 3 | Upper switch gates, bit 0 = leg a |
| gate_lo | output | 3 | Lower switch gates, bit 0 = leg a |

## Verification
The bench places a reference maximum of exactly 0 and a minimum of exactly 0 with the carrier one step on either side of ±K. A design that used the wrong inequality at zero would miss or invent a whole shoot-through interval there. It feeds K above half scale with the carrier just above and just at 2^(DW-2). A missing clamp leaves the upper gates unforced, and a clamp with an off-by-one error forces them at the wrong carrier value. It holds a reference exactly at the carrier to catch comparisons that are not strict, which would turn on one switch or both in a leg. A long sweep of random references and K over a triangular carrier, checked at a two-edge delay, exposes mixed-up leg bits, swapped envelopes and wrong latency.

// File: rtl/stpwm_pkg.sv
package stpwm_pkg;
  localparam int unsigned LEGS = 3;
  typedef enum logic [1:0] {LEG_A = 2'd0, LEG_B = 2'd1, LEG_C = 2'd2} leg_e;
endpackage

// File: rtl/stpwm_envelope.sv
module stpwm_envelope #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic signed [DW-1:0] ref_c,
  input  logic signed [DW-1:0] carrier,
  input  logic        [DW-2:0] k_off,
  output logic signed [DW-1:0] ra_q,
  output logic signed [DW-1:0] rb_q,
  output logic signed [DW-1:0] rc_q,
  output logic signed [DW-1:0] car_q,
  output logic signed [DW-1:0] mx_q,
  output logic signed [DW-1:0] mn_q,
  output logic signed [DW:0]   vp_q,
  output logic signed [DW:0]   vn_q
);
  localparam int unsigned KW = DW - 1;
  localparam int unsigned EW = DW + 1;
  localparam logic [KW-1:0] K_HALF = KW'(1) << (DW - 2);

  function automatic logic signed [DW-1:0] pick_max(
    input logic signed [DW-1:0] x, input logic signed [DW-1:0] y,
    input logic signed [DW-1:0] z);
    logic signed [DW-1:0] t;
    t = (x > y) ? x : y;
    return (t > z) ? t : z;
  endfunction

  function automatic logic signed [DW-1:0] pick_min(
    input logic signed [DW-1:0] x, input logic signed [DW-1:0] y,
    input logic signed [DW-1:0] z);
    logic signed [DW-1:0] t;
    t = (x < y) ? x : y;
    return (t < z) ? t : z;
  endfunction

  function automatic logic [KW-1:0] sat_k(input logic [KW-1:0] k);
    return (k > K_HALF) ? K_HALF : k;
  endfunction

  // lift the max by K over its non-positive stretch
  function automatic logic signed [EW-1:0] env_up(
    input logic signed [DW-1:0] m, input logic [KW-1:0] k);
    logic signed [EW-1:0] mw;
    mw = EW'(m);
    return (m > 0) ? mw : mw + $signed({2'b00, k});
  endfunction

  // lower the min by K over its non-negative stretch
  function automatic logic signed [EW-1:0] env_dn(
    input logic signed [DW-1:0] m, input logic [KW-1:0] k);
    logic signed [EW-1:0] mw;
    mw = EW'(m);
    return (m < 0) ? mw : mw - $signed({2'b00, k});
  endfunction

  logic signed [DW-1:0] mx_d, mn_d;
  logic        [KW-1:0] k_sat;
  logic signed [EW-1:0] vp_d, vn_d;

  always_comb begin
    mx_d  = pick_max(ref_a, ref_b, ref_c);
    mn_d  = pick_min(ref_a, ref_b, ref_c);
    k_sat = sat_k(k_off);
    vp_d  = env_up(mx_d, k_sat);
    vn_d  = env_dn(mn_d, k_sat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q  <= '0;
      rb_q  <= '0;
      rc_q  <= '0;
      car_q <= '0;
      mx_q  <= '0;
      mn_q  <= '0;
      vp_q  <= '0;
      vn_q  <= '0;
    end else begin
      ra_q  <= ref_a;
      rb_q  <= ref_b;
      rc_q  <= ref_c;
      car_q <= carrier;
      mx_q  <= mx_d;
      mn_q  <= mn_d;
      vp_q  <= vp_d;
      vn_q  <= vn_d;
    end
  end
endmodule

// File: rtl/stpwm_leg_cmp.sv
module stpwm_leg_cmp #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] ref_q,
  input  logic signed [DW-1:0] car_q,
  input  logic                 force_hi,
  input  logic                 force_lo,
  output logic                 gate_hi,
  output logic                 gate_lo
);
  logic above, below;

  always_comb begin
    above = ref_q > car_q;
    below = ref_q < car_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= above | force_hi;
      gate_lo <= below | force_lo;
    end
  end
endmodule

// File: rtl/stpwm_gate_gen.sv
module stpwm_gate_gen #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic signed [DW-1:0] ref_c,
  input  logic signed [DW-1:0] carrier,
  input  logic        [DW-2:0] k_off,
  output logic        [2:0]    gate_hi,
  output logic        [2:0]    gate_lo
);
  import stpwm_pkg::*;

  logic signed [DW-1:0] ra_q, rb_q, rc_q, car_q, mx_q, mn_q;
  logic signed [DW:0]   vp_q, vn_q, car_ext;
  logic                 st_hi_evt, st_lo_evt;
  logic signed [DW-1:0] ref_arr [LEGS];

  stpwm_envelope #(.DW(DW)) u_env (
    .clk(clk), .rst_n(rst_n),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .carrier(carrier), .k_off(k_off),
    .ra_q(ra_q), .rb_q(rb_q), .rc_q(rc_q), .car_q(car_q),
    .mx_q(mx_q), .mn_q(mn_q), .vp_q(vp_q), .vn_q(vn_q)
  );

  always_comb begin
    car_ext   = $signed({car_q[DW-1], car_q});
    st_hi_evt = vp_q < car_ext;
    st_lo_evt = vn_q > car_ext;
    ref_arr[LEG_A] = ra_q;
    ref_arr[LEG_B] = rb_q;
    ref_arr[LEG_C] = rc_q;
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    stpwm_leg_cmp #(.DW(DW)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .ref_q(ref_arr[g]), .car_q(car_q),
      .force_hi(st_hi_evt), .force_lo(st_lo_evt),
      .gate_hi(gate_hi[g]), .gate_lo(gate_lo[g])
    );
  end
endmodule

// File: rtl/stpwm_gate_chk.sv
module stpwm_gate_chk #(
  parameter int unsigned DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           gate_hi,
  input logic [2:0]           gate_lo,
  input logic signed [DW-1:0] ra_q,
  input logic signed [DW-1:0] rb_q,
  input logic signed [DW-1:0] rc_q,
  input logic signed [DW-1:0] car_q,
  input logic signed [DW-1:0] mx_q,
  input logic signed [DW-1:0] mn_q,
  input logic signed [DW:0]   vp_q,
  input logic signed [DW:0]   vn_q,
  input logic                 st_hi_evt,
  input logic                 st_lo_evt
);
  localparam logic signed [DW:0] HALF = (DW+1)'(1) << (DW - 2);
  logic [2:0] above, below;
  assign above = {rc_q > car_q, rb_q > car_q, ra_q > car_q};
  assign below = {rc_q < car_q, rb_q < car_q, ra_q < car_q};

  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |-> (gate_hi == 3'b000 && gate_lo == 3'b000));
  // R2
  upper_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gate_hi & $past(above)) == $past(above)));
  // R3
  lower_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gate_lo & $past(below)) == $past(below)));
  // R5
  st_upper_chk: assert property (@(posedge clk) disable iff (!rst_n) st_hi_evt |=> gate_hi == 3'b111);
  // R6
  st_lower_chk: assert property (@(posedge clk) disable iff (!rst_n) st_lo_evt |=> gate_lo == 3'b111);
  // R7
  env_up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_q >= $signed({mx_q[DW-1], mx_q})) && (vp_q - $signed({mx_q[DW-1], mx_q}) <= HALF));
  // R8
  env_dn_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vn_q <= $signed({mn_q[DW-1], mn_q})) && ($signed({mn_q[DW-1], mn_q}) - vn_q <= HALF));
  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_hi_evt && !st_lo_evt) |=> (gate_hi & gate_lo) == 3'b000);
endmodule

bind stpwm_gate_gen stpwm_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .ra_q(ra_q), .rb_q(rb_q), .rc_q(rc_q), .car_q(car_q),
  .mx_q(mx_q), .mn_q(mn_q), .vp_q(vp_q), .vn_q(vn_q),
  .st_hi_evt(st_hi_evt), .st_lo_evt(st_lo_evt)
);

// File: tb/stpwm_gate_gen_tb.sv
module stpwm_gate_gen_tb;
  localparam int DW = 16;
  localparam int HALF = 1 << (DW - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [DW-1:0] ref_a = '0, ref_b = '0, ref_c = '0, carrier = '0;
  logic [DW-2:0] k_off = '0;
  logic [2:0] gate_hi, gate_lo;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    int         due;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  stpwm_gate_gen #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .carrier(carrier), .k_off(k_off), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: R10 - each item is due two rising edges after it was driven
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (gate_hi !== e.hi || gate_lo !== e.lo) begin
        n_bad++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", e.tag, gate_hi, gate_lo, e.hi, e.lo);
      end
    end
  end

  task automatic drive(input int a, input int b, input int c, input int car, input int k, input string tag);
    int r[3];
    int top, bot, kk, up_env, dn_env;
    exp_t e;
    @(negedge clk);
    ref_a = DW'(a); ref_b = DW'(b); ref_c = DW'(c); carrier = DW'(car); k_off = (DW-1)'(k);
    r[0] = a; r[1] = b; r[2] = c;
    top = a; bot = a;
    for (int i = 1; i < 3; i++) begin
      if (r[i] > top) top = r[i];
      if (r[i] < bot) bot = r[i];
    end
    kk = (k < HALF) ? k : HALF;
    up_env = top;
    if (!(top > 0)) up_env = top + kk;
    dn_env = bot;
    if (!(bot < 0)) dn_env = bot - kk;
    for (int i = 0; i < 3; i++) begin
      e.hi[i] = (r[i] > car) || (up_env < car);
      e.lo[i] = (r[i] < car) || (dn_env > car);
    end
    e.due = cyc + 2;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: gates stay low in reset even with active-looking inputs
    ref_a = 16'sd1000; carrier = -16'sd500; k_off = 15'd100;
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (gate_hi !== 3'b000 || gate_lo !== 3'b000) begin
        n_bad++;
        $display("FAIL R1: hi=%b lo=%b expected hi=000 lo=000", gate_hi, gate_lo);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;

    drive(1000, -500, -500, 0, 0, "R2 R3 normal compare");
    drive(-100, -200, -300, 0, 50, "R5 upper force");
    drive(0, -4000, -8000, 999, 1000, "R7 max zero lifted, no force");
    drive(0, -4000, -8000, 1001, 1000, "R7 max zero lifted, force");
    drive(0, 5000, 9000, -1999, 2000, "R8 min zero lowered, no force");
    drive(0, 5000, 9000, -2001, 2000, "R8 R6 min zero lowered, force");
    drive(0, -3000, -6000, 16385, 20000, "R9 clamp force above half");
    drive(0, -3000, -6000, 16384, 20000, "R9 clamp boundary");
    drive(0, -3000, -6000, 16385, 32767, "R9 clamp max K");
    drive(0, -1, -2, 16384, 16383, "R9 unclamped below half");
    drive(300, -700, 400, 300, 0, "R4 R11 ref equals carrier");
    drive(-300, 700, -700, -700, 0, "R4 equal minimum leg");

    // triangular carrier sweep with random references and K
    begin
      int car_v = -20000, step = 397;
      for (int n = 0; n < 3000; n++) begin
        int a, b, c, k;
        a = int'($urandom_range(40000)) - 20000;
        b = int'($urandom_range(40000)) - 20000;
        c = int'($urandom_range(40000)) - 20000;
        k = int'($urandom_range(32767));
        drive(a, b, c, car_v, k, "R2 R3 R5 R6 R10 R11 sweep");
        if (car_v + step > 20000 || car_v + step < -20000) step = -step;
        car_v = car_v + step;
      end
    end

    repeat (5) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d results pending, expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule